// File: doc/BRIEF.md
# Serial Flash Clock and Select Timing Generator

This block turns a fast reference clock into the serial clock and the active-low chip-select waveforms that a serial flash master drives. A sequencer raises a transfer request with a length, measured in serial-clock cycles. The block asserts the chosen select line and waits a programmable lead time. It then emits the clock edges with one-cycle shift and sample strobes. After a programmable trailing time it releases the select and pulses a done flag. The data shift registers sit outside this block and follow the strobes.

All configuration is taken into a shadow copy only while the enable input is low and no transfer is running. Once enabled, the block ignores any changes on the configuration pins. Between transfers it holds the select lines high for a minimum deselect time. A longer hold-off applies when the next transfer addresses a different device pattern.

Top module: `sflash_timing_gen`

## Requirements
- R1: After reset, cs_n is all ones, idle is 1, sclk is 0, xfer_done, shift_stb and sample_stb are 0.
- R2: During a transfer, consecutive sclk edges are exactly baud_div+1 reference clocks apart, so one serial period is 2*(baud_div+1) reference clocks.
- R3: A transfer with length field L produces exactly 2*(L+1) sclk edges. Outside transfers, sclk rests at the level of cpol (0 or 1), and it returns there after the last edge.
- R4: Edges are numbered from 1, and odd-numbered edges are leading. With cpha=0, sample_stb pulses on leading edges and shift_stb on trailing edges; cpha=1 swaps them. Each pulse lasts one reference cycle and coincides with the new sclk level, and no strobe occurs without an edge.
- R5: With cs_decode=0, cs_n during a transfer is all ones except bit cs_field[1:0], which is 0 (field 2 gives 4'b1011, field 3 gives 4'b0111).
- R6: With cs_decode=1, cs_n during a transfer equals cs_field unchanged.
- R7: The first sclk edge comes lead_dly+1 reference clocks after cs_n is asserted.
- R8: cs_n returns to all ones trail_dly + 2*(baud_div+1) + 3 reference clocks after the last sclk edge. xfer_done is high for exactly that one cycle.
- R9: Between the release of cs_n and the next assertion there are at least gap_dly + 2*(baud_div+1) + 1 reference clocks. When a request is already waiting, the spacing is exactly that value.
- R10: If the select pattern differs from the previous transfer's, the spacing is also at least swap_dly reference clocks. An unchanged pattern is not delayed by swap_dly.
- R11: idle is 0 from the cycle cs_n is asserted until the cycle it is released, when idle returns to 1 together with xfer_done.
- R12: Configuration changes made while enable is 1 have no effect on the waveforms. While enable is 0, a request does not start a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Admits requests when high; configuration is captured when low and idle |
| baud_div | input | 4 | Half-period of sclk minus one, in reference clocks |
| cpol | input | 1 | Resting level of sclk |
| cpha | input | 1 | Selects which edge carries the sample strobe |
| cs_field | input | 4 | Device index (one-hot mode) or raw pin pattern (decoder mode) |
| cs_decode | input | 1 | 1: cs_field goes to the pins unchanged |
| lead_dly | input | 8 | Select-to-first-edge delay |
| trail_dly | input | 8 | Last-edge-to-release delay |
| gap_dly | input | 8 | Minimum deselect time |
| swap_dly | input | 8 | Minimum deselect time when the device changes |
| xfer_req | input | 1 | Transfer request, held until xfer_done |
| xfer_len | input | 8 | Serial-clock cycles in the transfer minus one |
| xfer_done | output | 1 | One-cycle pulse when the select is released |
| sclk | output | 1 | Serial clock |
| cs_n | output | 4 | Active-low chip-select bus |
| shift_stb | output | 1 | One-cycle strobe on the edge where data is launched |
| sample_stb | output | 1 | One-cycle strobe on the edge where data is captured |
| idle | output | 1 | High when no transfer is active |

## Verification
The main path is exercised with four configurations: mode 0 at the fastest divider, mode 3 at the slowest divider with a single clock cycle, phase 1 in decoder mode, and zero lead and trail delays. Together these separate the polarity, phase, divider and select-encoding paths, and they show whether the fixed extra cycles are counted correctly at both ends of their ranges. Back-to-back requests with a held request measure the exact deselect spacing. The same spacing is measured with the same device and then with a changed device, which shows whether the swap delay is applied only on a change. Changing the divider in the middle of a transfer, and raising a request while disabled, show that the shadowed configuration and the enable gate work.

// File: rtl/sftg_pkg.sv
package sftg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LEAD  = 2'd1,
    PH_CLK   = 2'd2,
    PH_TRAIL = 2'd3
  } phase_e;
endpackage

// File: rtl/sftg_cfg_shadow.sv
module sftg_cfg_shadow #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/sftg_cs_select.sv
module sftg_cs_select #(
  parameter int NCS = 4
) (
  input  logic [NCS-1:0] field,
  input  logic           decode,
  output logic [NCS-1:0] pat_n
);
  localparam int SELW = (NCS > 1) ? $clog2(NCS) : 1;

  logic [SELW-1:0] idx;
  logic [NCS-1:0]  onehot_n;

  assign idx = field[SELW-1:0];

  for (genvar i = 0; i < NCS; i++) begin : g_line
    assign onehot_n[i] = (idx != SELW'(i));
  end

  assign pat_n = decode ? field : onehot_n;
endmodule

// File: rtl/sftg_edge_gen.sv
module sftg_edge_gen #(
  parameter int LENW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [LENW-1:0] len,
  input  logic            fire,
  input  logic            rest,
  input  logic            rest_lvl,
  input  logic            cpha,
  output logic            sclk,
  output logic            last,
  output logic            shift_stb,
  output logic            sample_stb
);
  localparam int EW = LENW + 2;

  logic [EW-1:0] edges_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk       <= 1'b0;
      edges_left <= '0;
      shift_stb  <= 1'b0;
      sample_stb <= 1'b0;
    end else begin
      shift_stb  <= 1'b0;
      sample_stb <= 1'b0;
      if (load) edges_left <= (EW'(len) + EW'(1)) << 1;
      if (fire) begin
        sclk       <= ~sclk;
        edges_left <= edges_left - EW'(1);
        // even count left means an odd-numbered (leading) edge
        sample_stb <= cpha ? edges_left[0] : ~edges_left[0];
        shift_stb  <= cpha ? ~edges_left[0] : edges_left[0];
      end else if (rest) begin
        sclk <= rest_lvl;
      end
    end
  end

  assign last = (edges_left == EW'(1));

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_stb && sample_stb));
  // R2
  sclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !rest) |=> $stable(sclk));
  // R3
  edge_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (edges_left != '0));
endmodule

// File: rtl/sftg_holdoff.sv
module sftg_holdoff #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          count_en,
  input  logic [CW-1:0] gap_need,
  input  logic [CW-1:0] swap_need,
  input  logic          same_dev,
  output logic          hold_ok
);
  logic [CW-1:0] elapsed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         elapsed <= '1;
    else if (restart)                   elapsed <= CW'(1);
    else if (count_en && elapsed != '1) elapsed <= elapsed + CW'(1);
  end

  assign hold_ok = (elapsed >= gap_need) && (same_dev || elapsed >= swap_need);
endmodule

// File: rtl/sflash_timing_gen.sv
module sflash_timing_gen #(
  parameter int NCS  = 4,
  parameter int DIVW = 4,
  parameter int DLYW = 8,
  parameter int LENW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic [DIVW-1:0] baud_div,
  input  logic            cpol,
  input  logic            cpha,
  input  logic [NCS-1:0]  cs_field,
  input  logic            cs_decode,
  input  logic [DLYW-1:0] lead_dly,
  input  logic [DLYW-1:0] trail_dly,
  input  logic [DLYW-1:0] gap_dly,
  input  logic [DLYW-1:0] swap_dly,
  input  logic            xfer_req,
  input  logic [LENW-1:0] xfer_len,
  output logic            xfer_done,
  output logic            sclk,
  output logic [NCS-1:0]  cs_n,
  output logic            shift_stb,
  output logic            sample_stb,
  output logic            idle
);
  import sftg_pkg::*;

  localparam int WIDEST = (DLYW > DIVW + 1) ? DLYW : DIVW + 1;
  localparam int CW     = WIDEST + 2;
  localparam int CFGW   = DIVW + 2 + NCS + 1 + 4 * DLYW;

  // configuration shadow
  logic [CFGW-1:0] cfg_d, cfg_q;
  logic [DIVW-1:0] s_baud;
  logic            s_cpol, s_cpha, s_dec;
  logic [NCS-1:0]  s_field;
  logic [DLYW-1:0] s_lead, s_trail, s_gap, s_swap;
  phase_e          phase;

  assign cfg_d = {baud_div, cpol, cpha, cs_field, cs_decode,
                  lead_dly, trail_dly, gap_dly, swap_dly};
  assign {s_baud, s_cpol, s_cpha, s_field, s_dec,
          s_lead, s_trail, s_gap, s_swap} = cfg_q;

  sftg_cfg_shadow #(.W(CFGW)) u_shadow (
    .clk(clk), .rst_n(rst_n),
    .load(!enable && phase == PH_IDLE),
    .d(cfg_d), .q(cfg_q)
  );

  // derived timing values
  logic [CW-1:0] half_ld, period, trail_ld, gap_need, swap_need;
  assign half_ld   = CW'(s_baud);
  assign period    = (CW'(s_baud) + CW'(1)) << 1;
  assign trail_ld  = CW'(s_trail) + period + CW'(2);
  assign gap_need  = CW'(s_gap) + period + CW'(1);
  assign swap_need = CW'(s_swap);

  // select pattern
  logic [NCS-1:0] pat_n, last_pat;
  sftg_cs_select #(.NCS(NCS)) u_sel (
    .field(s_field), .decode(s_dec), .pat_n(pat_n)
  );

  // hold-off between transfers
  logic [CW-1:0] tmr;
  logic          hold_ok, launch, fire, last_edge, release_now;

  assign release_now = (phase == PH_TRAIL) && (tmr == '0);

  sftg_holdoff #(.CW(CW)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .restart(release_now), .count_en(phase == PH_IDLE),
    .gap_need(gap_need), .swap_need(swap_need),
    .same_dev(pat_n == last_pat), .hold_ok(hold_ok)
  );

  assign launch = (phase == PH_IDLE) && enable && xfer_req && hold_ok;
  assign fire   = ((phase == PH_LEAD) || (phase == PH_CLK)) && (tmr == '0);

  sftg_edge_gen #(.LENW(LENW)) u_edges (
    .clk(clk), .rst_n(rst_n),
    .load(launch), .len(xfer_len),
    .fire(fire), .rest(phase == PH_IDLE), .rest_lvl(s_cpol), .cpha(s_cpha),
    .sclk(sclk), .last(last_edge),
    .shift_stb(shift_stb), .sample_stb(sample_stb)
  );

  // sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      tmr       <= '0;
      cs_n      <= '1;
      last_pat  <= '1;
      xfer_done <= 1'b0;
    end else begin
      xfer_done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (launch) begin
            phase    <= PH_LEAD;
            tmr      <= CW'(s_lead);
            cs_n     <= pat_n;
            last_pat <= pat_n;
          end
        end
        PH_LEAD: begin
          if (tmr == '0) begin
            phase <= PH_CLK;
            tmr   <= half_ld;
          end else begin
            tmr <= tmr - CW'(1);
          end
        end
        PH_CLK: begin
          if (tmr == '0) begin
            if (last_edge) begin
              phase <= PH_TRAIL;
              tmr   <= trail_ld;
            end else begin
              tmr <= half_ld;
            end
          end else begin
            tmr <= tmr - CW'(1);
          end
        end
        PH_TRAIL: begin
          if (tmr == '0) begin
            phase     <= PH_IDLE;
            cs_n      <= '1;
            xfer_done <= 1'b1;
          end else begin
            tmr <= tmr - CW'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign idle = (phase == PH_IDLE);

  // R11
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (cs_n == '1));
  // R8
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> ((cs_n == '1) && ($past(cs_n) != '1)));
  // R12
  cfg_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> $stable(cfg_q));
  // R9
  launch_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle) |-> $past(hold_ok && enable));
endmodule

// File: tb/sflash_timing_gen_tb_top.sv
module sflash_timing_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tb_en = 1'b0;
  logic [3:0] tb_baud = '0;
  logic       tb_cpol = 1'b0, tb_cpha = 1'b0;
  logic [3:0] tb_sel = '0;
  logic       tb_dec = 1'b0;
  logic [7:0] tb_lead = '0, tb_trail = '0, tb_gap = '0, tb_swap = '0;
  logic       tb_req = 1'b0;
  logic [7:0] tb_len = '0;
  int         ex_baud = 0;

  logic       xfer_done, sclk, shift_stb, sample_stb, idle;
  logic [3:0] cs_n;

  always #5 clk = ~clk;

  sflash_timing_gen dut_i (
    .clk(clk), .rst_n(rst_n), .enable(tb_en),
    .baud_div(tb_baud), .cpol(tb_cpol), .cpha(tb_cpha),
    .cs_field(tb_sel), .cs_decode(tb_dec),
    .lead_dly(tb_lead), .trail_dly(tb_trail), .gap_dly(tb_gap), .swap_dly(tb_swap),
    .xfer_req(tb_req), .xfer_len(tb_len),
    .xfer_done(xfer_done), .sclk(sclk), .cs_n(cs_n),
    .shift_stb(shift_stb), .sample_stb(sample_stb), .idle(idle)
  );

  int n_chk = 0, n_bad = 0;

  task automatic check(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic logic [3:0] pat_of(input logic [3:0] s, input logic d);
    return d ? s : ~(4'b0001 << s[1:0]);
  endfunction

  // waveform monitor
  int ncyc = 0, t_fall = 0, t_rise = 0, t_first = 0, t_last = 0;
  int n_edges = 0, hp_min = 0, hp_max = 0, hi_time = 0;
  int n_samp = 0, n_shift = 0, strobe_err = 0, fall_pat = 0;
  int done_at_rise = 0, idle_at_fall = 1;
  logic [3:0] pcs = 4'hF;
  logic       psclk = 1'b0;

  always @(negedge clk) begin
    ncyc++;
    if (rst_n) begin
      if (pcs == 4'hF && cs_n != 4'hF) begin
        hi_time = ncyc - t_rise;  t_fall = ncyc;
        n_edges = 0; hp_min = 100000; hp_max = 0;
        n_samp = 0; n_shift = 0; strobe_err = 0;
        fall_pat = int'(cs_n); idle_at_fall = int'(idle);
      end
      if (cs_n != 4'hF && sclk != psclk) begin
        automatic int  k   = n_edges + 1;
        automatic bit  ld  = (k % 2) == 1;
        automatic bit  exs = tb_cpha ? !ld : ld;
        if (n_edges == 0) t_first = ncyc;
        else begin
          if (ncyc - t_last < hp_min) hp_min = ncyc - t_last;
          if (ncyc - t_last > hp_max) hp_max = ncyc - t_last;
        end
        t_last = ncyc;
        n_edges++;
        if (sample_stb !== exs || shift_stb !== !exs) strobe_err++;
        n_samp  += int'(sample_stb);
        n_shift += int'(shift_stb);
      end else if (sample_stb || shift_stb) begin
        strobe_err++;
      end
      if (pcs != 4'hF && cs_n == 4'hF) begin
        t_rise = ncyc;
        done_at_rise = int'(xfer_done);
      end
    end
    pcs = cs_n;
    psclk = sclk;
  end

  task automatic setcfg(input int baud, input bit pol, input bit pha,
                        input logic [3:0] sel, input bit dec,
                        input int lead, input int trail, input int gap, input int swp);
    @(negedge clk);
    tb_en = 1'b0;
    tb_baud = 4'(baud); ex_baud = baud;
    tb_cpol = pol; tb_cpha = pha; tb_sel = sel; tb_dec = dec;
    tb_lead = 8'(lead); tb_trail = 8'(trail); tb_gap = 8'(gap); tb_swap = 8'(swp);
    repeat (2) @(negedge clk);
    tb_en = 1'b1;
    @(negedge clk);
  endtask

  // one transfer with full waveform checks; poke>=0 changes the divider pin mid-transfer
  task automatic xfer(input string tag, input int len, input bit keep, input int poke);
    bit seen = 0;
    int h;
    tb_len = 8'(len);
    @(negedge clk);
    tb_req = 1'b1;
    if (poke >= 0) begin
      for (int i = 0; i < 3000 && cs_n == 4'hF; i++) @(negedge clk);
      tb_baud = 4'(poke);
    end
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (xfer_done) begin seen = 1; break; end
    end
    check({tag, " R8 done pulse seen"}, int'(seen), 1);
    check({tag, " R11 idle back with done"}, int'(idle), 1);
    if (!keep) tb_req = 1'b0;
    tb_baud = 4'(ex_baud);
    @(negedge clk);
    h = ex_baud + 1;
    check({tag, " R7 lead time"}, t_first - t_fall, int'(tb_lead) + 1);
    check({tag, " R3 edge count"}, n_edges, 2 * (len + 1));
    check({tag, " R2 min half period"}, hp_min, (len > 0 || n_edges > 1) ? h : hp_min);
    check({tag, " R2 max half period"}, hp_max, h);
    check({tag, " R8 trail time"}, t_rise - t_last, int'(tb_trail) + 2 * h + 3);
    check({tag, " R8 done with release"}, done_at_rise, 1);
    check({tag, " R4 strobe placement"}, strobe_err, 0);
    check({tag, " R4 sample count"}, n_samp, len + 1);
    check({tag, " R4 shift count"}, n_shift, len + 1);
    check({tag, " R5/R6 select pattern"}, fall_pat, int'(pat_of(tb_sel, tb_dec)));
    check({tag, " R11 idle low in transfer"}, idle_at_fall, 0);
    check({tag, " R3 sclk at rest"}, int'(sclk), int'(tb_cpol));
  endtask

  task automatic t_reset;
    check("R1 cs_n after reset", int'(cs_n), 15);
    check("R1 idle after reset", int'(idle), 1);
    check("R1 sclk after reset", int'(sclk), 0);
    check("R1 done after reset", int'(xfer_done), 0);
    check("R1 strobes after reset", int'(shift_stb) + int'(sample_stb), 0);
  endtask

  task automatic t_mode0;  // R2 R4 R5 R7 R8
    setcfg(0, 0, 0, 4'd2, 0, 2, 1, 3, 0);
    xfer("mode0", 3, 0, -1);
  endtask

  task automatic t_mode3;  // R3 polarity, R2 slowest divider, R5
    setcfg(15, 1, 1, 4'd3, 0, 4, 6, 2, 0);
    repeat (2) @(negedge clk);
    check("mode3 R3 rest level high", int'(sclk), 1);
    xfer("mode3", 0, 0, -1);
  endtask

  task automatic t_decode;  // R6 R4
    setcfg(2, 0, 1, 4'b1010, 1, 1, 2, 1, 0);
    xfer("decode", 5, 0, -1);
  endtask

  task automatic t_gap;  // R9
    setcfg(1, 0, 0, 4'd1, 0, 0, 0, 5, 0);
    xfer("gap_a", 1, 1, -1);
    xfer("gap_b", 1, 0, -1);
    check("R9 back-to-back deselect", hi_time, 5 + 4 + 1);
  endtask

  task automatic t_swap;  // R10
    setcfg(1, 0, 0, 4'd0, 0, 1, 1, 5, 120);
    xfer("swap_a", 0, 1, -1);
    xfer("swap_b", 0, 0, -1);
    check("R10 same device not delayed by swap", hi_time, 10);
    setcfg(1, 0, 0, 4'd1, 0, 1, 1, 5, 120);
    tb_req = 1'b1;
    xfer("swap_c", 0, 0, -1);
    check("R10 changed device waits swap delay", hi_time, 120);
  endtask

  task automatic t_frozen;  // R12
    setcfg(3, 0, 0, 4'd0, 0, 1, 1, 1, 0);
    xfer("frozen", 2, 0, 9);
    @(negedge clk);
    tb_en = 1'b0;
    tb_req = 1'b1;
    repeat (30) @(negedge clk);
    check("R12 no select while disabled", int'(cs_n), 15);
    check("R12 idle while disabled", int'(idle), 1);
    check("R12 no sclk activity while disabled", int'(sclk), 0);
    tb_en = 1'b1;
    xfer("after_enable", 0, 0, -1);
  endtask

  task automatic t_extreme;  // R7 R8 zero delays
    setcfg(0, 1, 0, 4'd0, 0, 0, 0, 0, 0);
    xfer("zero_dly", 0, 0, -1);
  endtask

  initial begin
    #1_900_000;
    n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode0();
    t_mode3();
    t_decode();
    t_gap();
    t_swap();
    t_frozen();
    t_extreme();
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule